// File: doc/BRIEF.md
# Latched Tri-Port Bus Exchanger

This block connects one 12-bit A port to two 12-bit B ports (B1 and B2). Each port has separate input and output buses and an output-enable flag, so no bidirectional pin is needed. On the path from A out to the B ports, each B port has its own storage element. One A word can be parked for B1 while a different word is parked for B2, which suits interleaved memory writes. On the path from the B ports back to A, each B port has its own input storage element, and a select picks which parked B word drives A. This suits multiplexing two address sources onto one bus.

Every storage element behaves as a transparent latch made from flops. While its enable is high, the output follows the input within the same cycle, and the value is sampled on each rising clock edge. While the enable is low, the output shows the word taken at the last rising edge on which the enable was high. Later changes on the input have no effect. Three output-enable inputs, one per port, gate the outputs. A gated-off port drives zero and lowers its valid flag. The data paths are level-controlled pass-through paths with no transfer handshake, so there is no back-pressure. Every pin is a plain control or data pin.

Top module: `xchg_tri_port`

## Requirements
- R1: After reset, all four storage elements hold zero. With every latch enable low and every output enabled, a_out, b1_out and b2_out read 0x000 until a latch is opened.
- R2: While ab1_le is high, b1_out equals a_in in the same cycle. While ab2_le is high, b2_out equals a_in in the same cycle.
- R3: When an A-to-B enable is low, its B output keeps the a_in value sampled at the last rising clock edge on which that enable was high. Changes on a_in while the enable is low do not appear on that output.
- R4: The B1 and B2 A-to-B storage elements are independent. Opening one leaves the word held by the other unchanged, so the two ports can hold different words.
- R5: When ab1_le and ab2_le are both high, the same a_in word reaches both B outputs. Closing both enables afterwards leaves that word on both.
- R6: While ba1_le is high, the B1-side word toward A follows b1_in; while it is low, that word keeps the b1_in value sampled at the last rising edge on which it was high. ba2_le does the same for b2_in.
- R7: a_sel = 0 routes the B1-side word to a_out and a_sel = 1 routes the B2-side word. Switching a_sel changes neither stored word.
- R8: Each output x_out has an enable input x_oe. When x_oe is low, x_out reads zero and x_vld is low. When x_oe is high, x_vld is high. The three enables act independently.
- R9: Storage elements capture data whether or not their port's output is enabled. A word captured while the output was gated off appears once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all storage elements |
| rst_n | input | 1 | Asynchronous active-low reset; clears stored words |
| a_in | input | 12 | Word arriving on the A port |
| a_out | output | 12 | Word driven onto the A port |
| a_oe | input | 1 | Output enable for the A port |
| a_vld | output | 1 | A port output is being driven |
| a_sel | input | 1 | 0 = B1-side word drives A, 1 = B2-side word |
| b1_in | input | 12 | Word arriving on port B1 |
| b1_out | output | 12 | Word driven onto port B1 |
| b1_oe | input | 1 | Output enable for port B1 |
| b1_vld | output | 1 | Port B1 output is being driven |
| b2_in | input | 12 | Word arriving on port B2 |
| b2_out | output | 12 | Word driven onto port B2 |
| b2_oe | input | 1 | Output enable for port B2 |
| b2_vld | output | 1 | Port B2 output is being driven |
| ab1_le | input | 1 | Enable of the A-to-B1 storage element |
| ab2_le | input | 1 | Enable of the A-to-B2 storage element |
| ba1_le | input | 1 | Enable of the B1-to-A storage element |
| ba2_le | input | 1 | Enable of the B2-to-A storage element |

## Verification
The bench opens an enable across one clock edge and then closes it while it moves the input. A design that captured on the falling enable, or that kept following the input, would show the new word instead of the held one. It parks different words for B1 and B2. Storage shared between the ports, or an enable wired to the wrong port, would overwrite the first word. It toggles a_sel between the held B-side words and gates outputs off while capture goes on. A mux that reloads storage, or a capture path tied to the output enable, would show a stale or zero word once the output is enabled again.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int XCHG_W_DEF = 12;
  localparam int XCHG_NB    = 2;

  typedef enum logic {
    SEL_B1 = 1'b0,
    SEL_B2 = 1'b1
  } xchg_sel_e;
endpackage

// File: rtl/xchg_hold_latch.sv
module xchg_hold_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  // Sample on each rising edge while open; keep the word while closed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  held <= '0;
    else if (le) held <= d;
  end

  // Pass-through while open gives same-cycle transparency.
  assign q = le ? d : held;

  // R3 / R6: after closing, the output shows the word sampled at the last open edge.
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(le) && !le) |-> (q == $past(d)));

  // R3 / R6: while closed on two edges running, the output stays put.
  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(le) && !le) |-> $stable(q));
endmodule

// File: rtl/xchg_bport.sv
module xchg_bport #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_word,
  input  logic         dn_le,
  input  logic         up_le,
  input  logic [W-1:0] port_in,
  input  logic         oe,
  output logic [W-1:0] port_out,
  output logic         port_vld,
  output logic [W-1:0] up_word
);
  logic [W-1:0] dn_word;

  xchg_hold_latch #(.W(W)) dn_lat_i (
    .clk(clk), .rst_n(rst_n), .le(dn_le), .d(a_word), .q(dn_word)
  );

  xchg_hold_latch #(.W(W)) up_lat_i (
    .clk(clk), .rst_n(rst_n), .le(up_le), .d(port_in), .q(up_word)
  );

  assign port_out = oe ? dn_word : '0;
  assign port_vld = oe;

  // R9: a word captured on the A-to-B path reaches the pins once enabled.
  a_r9_enabled_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dn_le) && !dn_le && oe) |-> (port_out == $past(a_word)));
endmodule

// File: rtl/xchg_a_mux.sv
module xchg_a_mux #(
  parameter int W  = 12,
  parameter int NB = 2
) (
  input  xchg_pkg::xchg_sel_e  sel,
  input  logic [W-1:0]         words [NB],
  input  logic                 oe,
  output logic [W-1:0]         a_out,
  output logic                 a_vld
);
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [IW-1:0] idx;
  logic [W-1:0]  picked;

  assign idx = IW'(sel);

  always_comb begin
    picked = '0;
    for (int i = 0; i < NB; i++) begin
      if (idx == IW'(i)) picked = words[i];
    end
  end

  assign a_out = oe ? picked : '0;
  assign a_vld = oe;
endmodule

// File: rtl/xchg_tri_port.sv
module xchg_tri_port #(
  parameter int W = xchg_pkg::XCHG_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  input  logic         a_oe,
  output logic         a_vld,
  input  logic         a_sel,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  input  logic         b1_oe,
  output logic         b1_vld,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  input  logic         b2_oe,
  output logic         b2_vld,
  input  logic         ab1_le,
  input  logic         ab2_le,
  input  logic         ba1_le,
  input  logic         ba2_le
);
  import xchg_pkg::*;
  localparam int NB = XCHG_NB;

  logic [W-1:0] pin_in  [NB];
  logic [W-1:0] pin_out [NB];
  logic [W-1:0] up_word [NB];
  logic         pin_vld [NB];
  logic         dn_le   [NB];
  logic         up_le   [NB];
  logic         pin_oe  [NB];

  assign pin_in[0] = b1_in;
  assign pin_in[1] = b2_in;
  assign dn_le[0]  = ab1_le;
  assign dn_le[1]  = ab2_le;
  assign up_le[0]  = ba1_le;
  assign up_le[1]  = ba2_le;
  assign pin_oe[0] = b1_oe;
  assign pin_oe[1] = b2_oe;

  for (genvar g = 0; g < NB; g++) begin : g_bport
    xchg_bport #(.W(W)) bport_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_word  (a_in),
      .dn_le   (dn_le[g]),
      .up_le   (up_le[g]),
      .port_in (pin_in[g]),
      .oe      (pin_oe[g]),
      .port_out(pin_out[g]),
      .port_vld(pin_vld[g]),
      .up_word (up_word[g])
    );
  end

  assign b1_out = pin_out[0];
  assign b1_vld = pin_vld[0];
  assign b2_out = pin_out[1];
  assign b2_vld = pin_vld[1];

  xchg_a_mux #(.W(W), .NB(NB)) a_mux_i (
    .sel  (xchg_sel_e'(a_sel)),
    .words(up_word),
    .oe   (a_oe),
    .a_out(a_out),
    .a_vld(a_vld)
  );

  // R7: an open B1-side element with select 0 passes b1_in straight to A.
  a_r7_pick_b1: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && !a_sel && ba1_le) |-> (a_out == b1_in));

  // R7: an open B2-side element with select 1 passes b2_in straight to A.
  a_r7_pick_b2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && a_sel && ba2_le) |-> (a_out == b2_in));
endmodule

// File: tb/xchg_tri_port_tb.sv
module xchg_tri_port_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic a_oe = 1'b1, b1_oe = 1'b1, b2_oe = 1'b1, a_sel = 1'b0;
  logic ab1_le = 1'b0, ab2_le = 1'b0, ba1_le = 1'b0, ba2_le = 1'b0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_vld, b1_vld, b2_vld;

  always #2 clk = ~clk;

  xchg_tri_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_vld(a_vld), .a_sel(a_sel),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe), .b1_vld(b1_vld),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe), .b2_vld(b2_vld),
    .ab1_le(ab1_le), .ab2_le(ab2_le), .ba1_le(ba1_le), .ba2_le(ba2_le)
  );

  typedef struct {
    logic [W-1:0] ea, eb1, eb2;
    logic         va, vb1, vb2;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Driver: apply inputs just after a rising edge and queue the expected outputs.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] i1, input logic [W-1:0] i2,
                      input logic [3:0] le, input logic sel, input logic [2:0] oe,
                      input logic [W-1:0] ea, input logic [W-1:0] eb1, input logic [W-1:0] eb2,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a_in = a; b1_in = i1; b2_in = i2;
    {ab1_le, ab2_le, ba1_le, ba2_le} = le;
    a_sel = sel;
    {a_oe, b1_oe, b2_oe} = oe;
    e.va = oe[2]; e.vb1 = oe[1]; e.vb2 = oe[0];
    e.ea  = oe[2] ? ea  : '0;
    e.eb1 = oe[1] ? eb1 : '0;
    e.eb2 = oe[0] ? eb2 : '0;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic chk(input string tag, input string what, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare at the falling edge, midway between drive and next capture.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, "a",  {a_vld,  a_out},  {e.va,  e.ea});
      chk(e.tag, "b1", {b1_vld, b1_out}, {e.vb1, e.eb1});
      chk(e.tag, "b2", {b2_vld, b2_out}, {e.vb2, e.eb2});
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // le = {ab1, ab2, ba1, ba2}, oe = {a, b1, b2}
    step(12'h7E7, 12'h1AA, 12'h2BB, 4'b0000, 1'b0, 3'b111, 12'h000, 12'h000, 12'h000, "R1");
    step(12'h123, 12'h000, 12'h000, 4'b1000, 1'b0, 3'b111, 12'h000, 12'h123, 12'h000, "R2");
    step(12'h456, 12'h000, 12'h000, 4'b0000, 1'b0, 3'b111, 12'h000, 12'h123, 12'h000, "R3");
    step(12'h789, 12'h000, 12'h000, 4'b0100, 1'b0, 3'b111, 12'h000, 12'h123, 12'h789, "R4");
    step(12'hABC, 12'h000, 12'h000, 4'b0000, 1'b0, 3'b111, 12'h000, 12'h123, 12'h789, "R4");
    step(12'h5A5, 12'h000, 12'h000, 4'b1100, 1'b0, 3'b111, 12'h000, 12'h5A5, 12'h5A5, "R5");
    step(12'h000, 12'h000, 12'h000, 4'b0000, 1'b0, 3'b111, 12'h000, 12'h5A5, 12'h5A5, "R5");
    step(12'h000, 12'h111, 12'h222, 4'b0010, 1'b0, 3'b111, 12'h111, 12'h5A5, 12'h5A5, "R6");
    step(12'h000, 12'hFFF, 12'h222, 4'b0000, 1'b0, 3'b111, 12'h111, 12'h5A5, 12'h5A5, "R6");
    step(12'h000, 12'hFFF, 12'h222, 4'b0000, 1'b1, 3'b111, 12'h000, 12'h5A5, 12'h5A5, "R7");
    step(12'h000, 12'hFFF, 12'h333, 4'b0001, 1'b1, 3'b111, 12'h333, 12'h5A5, 12'h5A5, "R7");
    step(12'h000, 12'hFFF, 12'h444, 4'b0000, 1'b1, 3'b111, 12'h333, 12'h5A5, 12'h5A5, "R7");
    step(12'h000, 12'hFFF, 12'h444, 4'b0000, 1'b0, 3'b111, 12'h111, 12'h5A5, 12'h5A5, "R7");
    step(12'h000, 12'hFFF, 12'h444, 4'b0000, 1'b0, 3'b101, 12'h111, 12'h5A5, 12'h5A5, "R8");
    step(12'h000, 12'hFFF, 12'h444, 4'b0000, 1'b1, 3'b010, 12'h333, 12'h5A5, 12'h5A5, "R8");
    step(12'h0F0, 12'h0AA, 12'h444, 4'b1010, 1'b0, 3'b000, 12'h0AA, 12'h0F0, 12'h5A5, "R9");
    step(12'hF0F, 12'h055, 12'h444, 4'b0000, 1'b0, 3'b111, 12'h0AA, 12'h0F0, 12'h5A5, "R9");
    step(12'hF0F, 12'h055, 12'h444, 4'b0000, 1'b1, 3'b111, 12'h333, 12'h0F0, 12'h5A5, "R9");
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    #1 rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    step(12'h3C3, 12'h055, 12'h444, 4'b0000, 1'b1, 3'b111, 12'h000, 12'h000, 12'h000, "R1");
    step(12'h3C3, 12'h055, 12'h444, 4'b0000, 1'b0, 3'b111, 12'h000, 12'h000, 12'h000, "R1");
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule